// File: doc/BRIEF.md
# Indexed-Indirect Address Sequencer

This block drives the bus cycles of an 8-bit processor for one read instruction that uses zero-page pre-indexed indirect addressing. A one-cycle start pulse begins the sequence. The block then performs six read cycles in a row. The first two cycles read the opcode and the pointer byte at the program counter, and each of them asks for a program-counter increment. The third cycle is a dummy read at the pointer as fetched, and during it the X index is added to the pointer. The fourth and fifth cycles fetch the two bytes of the effective address from zero page. The sixth cycle reads the operand at that 16-bit address.

The program counter lives outside the block. The block reads its value on an input and asks for an increment with a pulse. Memory returns data in the same cycle as the address, on the data input. In the cycle after the operand read, the operand appears on a data output together with a one-cycle done pulse. The sequencer is then idle again and takes the next start.

Top module: `ixind_seq`

## Requirements
- R1: A start pulse seen while the block is idle begins six read cycles in a row, starting in the next clock cycle. The read strobe is high in exactly those six cycles.
- R2: In read cycles 1 and 2 the address equals the program-counter input. The increment request is high in those two cycles and low in every other cycle.
- R3: Read cycle 3 addresses {0x00, P}, where P is the byte read in cycle 2. The byte read in cycle 3 does not affect any later address or the delivered data.
- R4: Read cycle 4 addresses {0x00, (P+X) mod 256}. Read cycle 5 addresses {0x00, (P+X+1) mod 256}. No carry reaches the high address byte, so a sum of 0xFF is followed by 0x00.
- R5: Read cycle 6 addresses {H, L}. L is the byte read in cycle 4 and H is the byte read in cycle 5.
- R6: In the clock cycle after read cycle 6, done is high for exactly one cycle. In that cycle the data output equals the byte read in cycle 6, and it keeps that value until the next done.
- R7: A start pulse that arrives while a sequence is running is ignored. The running sequence is unchanged, and no further reads follow it.
- R8: A synchronous active-high reset returns the block to idle. While reset is held, the read strobe, increment request, done and address are all zero. A sequence that was cut off by reset does not resume.
- R9: A start pulse given in the same cycle as done is accepted. The next sequence follows with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sequence when the block is idle |
| pc_in | input | 16 | Current program-counter value |
| x_idx | input | 8 | X index register value |
| rdata | input | 8 | Read data returned for the current address |
| addr | output | 16 | Address bus |
| rd | output | 1 | Read strobe |
| pc_inc | output | 1 | Program-counter increment request |
| data_out | output | 8 | Operand from the final read |
| done | output | 1 | One-cycle pulse marking data_out valid |

## Verification
The hardest condition to reach is the zero-page wrap, where the second pointer fetch has to fall back to address 0x0000 and must not reach 0x0100. The stimulus reaches it by choosing pointer and index values whose sum is exactly 0xFF, and a second pair whose sum passes 256. The other hard conditions depend on timing. A start pulse is injected in the middle of a sequence, and a second start is placed in the cycle that carries done. Reset is asserted in the middle of a sequence, and the bench then confirms that the aborted trace produces no further bus activity.

// File: rtl/ixind_seq.sv
module ixind_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] pc_in,
  input  logic [7:0]  x_idx,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        rd,
  output logic        pc_inc,
  output logic [7:0]  data_out,
  output logic        done
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPC  = 3'd1,
    S_PTR  = 3'd2,
    S_DUM  = 3'd3,
    S_LO   = 3'd4,
    S_HI   = 3'd5,
    S_FIN  = 3'd6
  } st_t;

  st_t        st;
  logic [7:0] ptr;
  logic [7:0] zp;
  logic [7:0] lo;
  logic [7:0] hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ptr      <= 8'h00;
      zp       <= 8'h00;
      lo       <= 8'h00;
      hi       <= 8'h00;
      data_out <= 8'h00;
      done     <= 1'b0;
    end else begin
      done <= (st == S_FIN);
      case (st)
        S_IDLE: if (start) st <= S_OPC;
        S_OPC:  st <= S_PTR;
        S_PTR: begin
          ptr <= rdata;
          st  <= S_DUM;
        end
        S_DUM: begin
          zp <= ptr + x_idx;
          st <= S_LO;
        end
        S_LO: begin
          lo <= rdata;
          st <= S_HI;
        end
        S_HI: begin
          hi <= rdata;
          st <= S_FIN;
        end
        S_FIN: begin
          data_out <= rdata;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_OPC, S_PTR: addr = pc_in;
      S_DUM:        addr = {8'h00, ptr};
      S_LO:         addr = {8'h00, zp};
      S_HI:         addr = {8'h00, zp + 8'd1};
      S_FIN:        addr = {hi, lo};
      default:      addr = 16'h0000;
    endcase
  end

  assign rd     = (st != S_IDLE);
  assign pc_inc = (st == S_OPC) || (st == S_PTR);

endmodule

// File: rtl/ixind_seq_chk.sv
module ixind_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  st,
  input logic [15:0] addr,
  input logic        rd,
  input logic        pc_inc,
  input logic        done,
  input logic [7:0]  rdata
);
  localparam logic [2:0] C_OPC = 3'd1;
  localparam logic [2:0] C_PTR = 3'd2;
  localparam logic [2:0] C_DUM = 3'd3;
  localparam logic [2:0] C_LO  = 3'd4;
  localparam logic [2:0] C_HI  = 3'd5;
  localparam logic [2:0] C_FIN = 3'd6;

  a_r2_inc_only_in_fetch: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> rd && (st == C_OPC || st == C_PTR));

  a_r4_zero_page_high: assert property (@(posedge clk) disable iff (rst)
    (st == C_DUM || st == C_LO || st == C_HI) |-> addr[15:8] == 8'h00);

  a_r4_second_byte_wraps: assert property (@(posedge clk) disable iff (rst)
    (st == C_HI) |-> addr[7:0] == $past(addr[7:0]) + 8'd1);

  a_r5_high_from_prev_read: assert property (@(posedge clk) disable iff (rst)
    (st == C_FIN) |-> addr[15:8] == $past(rdata));

  a_r6_done_follows_final: assert property (@(posedge clk) disable iff (rst)
    (st == C_FIN) |=> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rd && !pc_inc && !done);
endmodule

bind ixind_seq ixind_seq_chk u_chk (
  .clk(clk), .rst(rst), .st(st), .addr(addr), .rd(rd),
  .pc_inc(pc_inc), .done(done), .rdata(rdata)
);

// File: tb/ixind_seq_tb.sv
module ixind_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic [7:0]  x_idx = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rd, pc_inc, done;
  logic [7:0]  data_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct packed { logic [15:0] a; logic inc; logic [2:0] c; } bus_t;
  bus_t       bq[$];
  logic [7:0] dq[$];
  logic [7:0] ovr[int];
  bit         in_seq = 1'b0;

  always #4 clk = ~clk;

  ixind_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc), .x_idx(x_idx),
    .rdata(rdata), .addr(addr), .rd(rd), .pc_inc(pc_inc),
    .data_out(data_out), .done(done)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'hA5;
  endfunction

  assign rdata = mem(addr);

  always_ff @(posedge clk) begin
    if (pc_inc) pc <= pc + 16'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare bus trace and delivered data against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd) begin
        if (bq.size() == 0) begin
          chk(1'b0, "R7", "read with nothing expected", int'(addr), 0);
        end else begin
          bus_t e;
          string tg;
          e = bq.pop_front();
          tg = (e.c <= 3'd2) ? "R2" : (e.c == 3'd3) ? "R3" :
               (e.c == 3'd6) ? "R5" : "R4";
          chk(addr == e.a, tg, $sformatf("address in cycle %0d", e.c),
              int'(addr), int'(e.a));
          chk(pc_inc == e.inc, "R2", "increment request", int'(pc_inc), int'(e.inc));
          in_seq = (e.c != 3'd6);
        end
      end else begin
        if (in_seq) chk(1'b0, "R1", "read strobe dropped mid sequence", 0, 1);
        in_seq = 1'b0;
        if (pc_inc) chk(1'b0, "R2", "increment without read", 1, 0);
      end
      if (done) begin
        if (dq.size() == 0) chk(1'b0, "R6", "unexpected done", int'(data_out), 0);
        else begin
          logic [7:0] d;
          d = dq.pop_front();
          chk(data_out == d, "R6", "delivered operand", int'(data_out), int'(d));
        end
      end
    end
  end

  // driver: load memory, push expectations, pulse start
  task automatic run(input logic [7:0] x, input logic [7:0] p,
                     input logic [7:0] l, input logic [7:0] h,
                     input logic [7:0] v, input int poke, input bit wait_done);
    logic [15:0] pc0;
    logic [7:0]  s;
    pc0 = pc;
    s = p + x;
    ovr[int'(pc0 + 16'd1)] = p;
    ovr[int'({8'h00, s})] = l;
    ovr[int'({8'h00, 8'(s + 8'd1)})] = h;
    ovr[int'({h, l})] = v;
    x_idx = x;
    bq.push_back('{pc0, 1'b1, 3'd1});
    bq.push_back('{pc0 + 16'd1, 1'b1, 3'd2});
    bq.push_back('{{8'h00, p}, 1'b0, 3'd3});
    bq.push_back('{{8'h00, s}, 1'b0, 3'd4});
    bq.push_back('{{8'h00, 8'(s + 8'd1)}, 1'b0, 3'd5});
    bq.push_back('{{h, l}, 1'b0, 3'd6});
    dq.push_back(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke - 1) @(negedge clk);
      start = 1'b1;  // R7: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    if (wait_done) while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd && !pc_inc && !done && addr == 16'h0, "R8", "outputs under reset",
        int'({rd, pc_inc, done}), 0);
    rst = 1'b0;
    pc = 16'h0400;
    @(negedge clk);

    run(8'h04, 8'h20, 8'h34, 8'h12, 8'h5C, 0, 1'b1);   // R1 R3 R4 R5 R6 basic
    chk(data_out == 8'h5C, "R6", "operand at done", int'(data_out), 8'h5C);
    @(negedge clk);
    chk(!rd && !done, "R6", "done lasts one cycle", int'(done), 0);
    chk(data_out == 8'h5C, "R6", "operand held after done", int'(data_out), 8'h5C);

    run(8'h0F, 8'hF0, 8'h00, 8'h80, 8'hC3, 0, 1'b1);   // R4 sum 0xFF wraps to 0x00
    @(negedge clk);
    run(8'h20, 8'hF0, 8'hEF, 8'h3B, 8'h71, 0, 1'b1);   // R4 sum passes 256
    @(negedge clk);

    run(8'h01, 8'h40, 8'h99, 8'h55, 8'h0E, 2, 1'b1);   // R7 start mid sequence
    repeat (3) begin
      @(negedge clk);
      chk(!rd, "R7", "no reads after ignored start", int'(rd), 0);
    end
    chk(bq.size() == 0, "R1", "six reads consumed", bq.size(), 0);

    run(8'h02, 8'h60, 8'h10, 8'h22, 8'hA1, 0, 1'b1);   // R9 back to back
    run(8'h03, 8'h70, 8'h20, 8'h23, 8'hB2, 0, 1'b1);
    chk(data_out == 8'hB2, "R9", "second operand", int'(data_out), 8'hB2);
    @(negedge clk);

    run(8'h05, 8'h80, 8'h30, 8'h24, 8'hC4, 0, 1'b0);   // R8 reset mid sequence
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!rd && !pc_inc && !done && addr == 16'h0, "R8", "outputs after reset",
        int'(addr), 0);
    bq.delete();
    dq.delete();
    in_seq = 1'b0;
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!rd && !done, "R8", "aborted sequence stays idle", int'(rd), 0);
    end

    run(8'h06, 8'h90, 8'h40, 8'h25, 8'hD5, 0, 1'b1);   // R8 clean restart
    @(negedge clk);
    chk(bq.size() == 0 && dq.size() == 0, "R1", "scoreboard drained",
        bq.size() + dq.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule